// File: doc/BRIEF.md
# Re-reference Interval Replacement Selector

This block keeps the replacement state of a single set of a set-associative cache and picks the way to evict. Each way has a valid bit and a small saturating re-reference prediction value (RRPV). A low RRPV means the line is expected to be used again soon. The maximum value means the line is not expected back. Lookups report a hit or a miss. A hit marks the way as recently useful. A miss starts a victim search, and the cache controller answers the result with a fill of the chosen way.

A victim search first takes any invalid way. If every way is valid, it takes a way whose RRPV is saturated. If no way is saturated, the block ages the whole set by one step per clock until at least one way saturates. Ties always go to the lowest way index. While a search runs the block reports busy and ignores lookups and fills. The result is shown for exactly one cycle through `victim_valid` and `victim_way`.

Top module: `rrip_victim_sel`

## Requirements
- R1: After reset, `way_valid` is all zero, every RRPV reads the maximum value 2^RRPV_BITS-1 (7 by default), and `busy` and `victim_valid` are low. In `set_rrpv`, the RRPV of way i sits at bits [i*RRPV_BITS +: RRPV_BITS].
- R2: A fill accepted while idle (`fill_valid` high, `busy` low) sets the valid bit of `fill_way` and sets its RRPV to FILL_RRPV (6 by default) at the next edge. The other ways are unchanged. When a fill and a hit target the same way in the same cycle, the fill wins.
- R3: An accepted hit (`lookup_valid` and `lookup_hit` high, `busy` low) to a valid way sets that way's RRPV to 0 and leaves every other way unchanged. A hit to an invalid way changes nothing.
- R4: On an accepted miss (`lookup_valid` high, `lookup_hit` low) with at least one invalid way, `victim_valid` rises in the first cycle after acceptance and names the lowest-index invalid way. No RRPV changes.
- R5: On an accepted miss with all ways valid and at least one RRPV at the maximum, `victim_valid` rises in the first cycle after acceptance and names the lowest-index saturated way.
- R6: On an accepted miss with all ways valid and a highest RRPV m below the maximum, every RRPV grows by one per cycle. `victim_valid` rises 7-m cycles after the first search cycle (with default width). It names the lowest-index way whose RRPV was m, and every way ends at its old value plus 7-m.
- R7: `busy` is high from the cycle after an accepted miss up to and including the cycle that shows the victim, and low in the cycle after that. Hits, misses and fills presented while `busy` is high have no effect on any state.
- R8: `victim_valid` is high for exactly one cycle per accepted miss, and only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | A lookup result for this set is presented |
| lookup_hit | input | 1 | 1 = hit, 0 = miss (starts a victim search) |
| lookup_way | input | WAY_W | Way that hit |
| fill_valid | input | 1 | A line is being written into the set |
| fill_way | input | WAY_W | Way being filled |
| busy | output | 1 | Victim search in progress; inputs ignored |
| victim_valid | output | 1 | One-cycle strobe: `victim_way` holds the chosen way |
| victim_way | output | WAY_W | Way selected for eviction |
| way_valid | output | NUM_WAYS | Per-way valid bits |
| set_rrpv | output | NUM_WAYS*RRPV_BITS | Current RRPV of every way, way i at [i*RRPV_BITS +: RRPV_BITS] |

## Verification
The hardest state to reach from the ports is a fully valid set whose RRPVs are spread out, so that aging must run for a known number of cycles and the lowest-index tie-break decides the outcome. RRPVs can only be set to 6 by a fill or to 0 by a hit, so the bench fills every way and then runs a long chain of hit masks, misses and refills. Aging from earlier misses carries forward, which gives many different value mixes. A reference model in the bench predicts the aging count and the victim for each step. One search is disturbed with a hit, a fill and a second miss while it runs, to show that these are ignored.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } rrip_state_e;

endpackage

// File: rtl/rrip_lowest_pick.sv
// Priority picker: reports whether any request bit is set and the
// index of the lowest set bit.
module rrip_lowest_pick #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0] req,
    output logic                found,
    output logic [WAY_W-1:0]    idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/rrip_age_lane.sv
// One way's aging lane: saturation detect and the next-aged value.
module rrip_age_lane #(
    parameter int RRPV_BITS = 3,
    localparam logic [RRPV_BITS-1:0] RRPV_MAX = {RRPV_BITS{1'b1}}
) (
    input  logic [RRPV_BITS-1:0] cur,
    output logic                 sat,
    output logic [RRPV_BITS-1:0] aged
);

    always_comb begin
        sat  = (cur == RRPV_MAX);
        aged = sat ? cur : cur + 1'b1;
    end

endmodule

// File: rtl/rrip_victim_sel.sv
module rrip_victim_sel
    import rrip_pkg::*;
#(
    parameter int NUM_WAYS  = 4,
    parameter int RRPV_BITS = 3,
    parameter int FILL_RRPV = (1 << RRPV_BITS) - 2,
    localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int RRPV_MAX = (1 << RRPV_BITS) - 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lookup_valid,
    input  logic                          lookup_hit,
    input  logic [WAY_W-1:0]              lookup_way,
    input  logic                          fill_valid,
    input  logic [WAY_W-1:0]              fill_way,
    output logic                          busy,
    output logic                          victim_valid,
    output logic [WAY_W-1:0]              victim_way,
    output logic [NUM_WAYS-1:0]           way_valid,
    output logic [NUM_WAYS*RRPV_BITS-1:0] set_rrpv
);

    typedef logic [RRPV_BITS-1:0] rrpv_t;

    typedef struct packed {
        rrip_state_e                st;
        logic [NUM_WAYS-1:0]        vld;
        logic [NUM_WAYS-1:0][RRPV_BITS-1:0] rrpv;
    } set_state_t;

    set_state_t s_d, s_q;

    logic [NUM_WAYS-1:0]                 sat_vec;
    logic [NUM_WAYS-1:0][RRPV_BITS-1:0]  aged_vec;
    logic                                inv_found, sat_found;
    logic [WAY_W-1:0]                    inv_idx, sat_idx;
    logic                                searching;
    logic                                pick_ok;

    // Per-way aging lanes
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_lane
        rrip_age_lane #(.RRPV_BITS(RRPV_BITS)) u_lane (
            .cur  (s_q.rrpv[g]),
            .sat  (sat_vec[g]),
            .aged (aged_vec[g])
        );
    end

    // Invalid ways take precedence over any RRPV search
    rrip_lowest_pick #(.NUM_WAYS(NUM_WAYS)) u_pick_inv (
        .req   (~s_q.vld),
        .found (inv_found),
        .idx   (inv_idx)
    );

    rrip_lowest_pick #(.NUM_WAYS(NUM_WAYS)) u_pick_sat (
        .req   (sat_vec),
        .found (sat_found),
        .idx   (sat_idx)
    );

    assign searching = (s_q.st == ST_SEARCH);
    assign pick_ok   = inv_found | sat_found;

    always_comb begin
        s_d = s_q;
        if (searching) begin
            if (pick_ok) begin
                s_d.st = ST_IDLE;
            end else begin
                for (int i = 0; i < NUM_WAYS; i++) begin
                    s_d.rrpv[i] = aged_vec[i];
                end
            end
        end else begin
            if (lookup_valid && !lookup_hit) begin
                s_d.st = ST_SEARCH;
            end
            for (int i = 0; i < NUM_WAYS; i++) begin
                if (lookup_valid && lookup_hit && (lookup_way == WAY_W'(i)) && s_q.vld[i]) begin
                    s_d.rrpv[i] = '0;
                end
                if (fill_valid && (fill_way == WAY_W'(i))) begin
                    s_d.vld[i]  = 1'b1;
                    s_d.rrpv[i] = rrpv_t'(FILL_RRPV);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= ST_IDLE;
            s_q.vld <= '0;
            for (int i = 0; i < NUM_WAYS; i++) begin
                s_q.rrpv[i] <= rrpv_t'(RRPV_MAX);
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign busy         = searching;
    assign victim_valid = searching & pick_ok;
    assign victim_way   = inv_found ? inv_idx : sat_idx;
    assign way_valid    = s_q.vld;
    assign set_rrpv     = s_q.rrpv;

endmodule

// File: rtl/rrip_victim_sel_chk.sv
module rrip_victim_sel_chk #(
    parameter int NUM_WAYS  = 4,
    parameter int RRPV_BITS = 3,
    localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int RRPV_MAX = (1 << RRPV_BITS) - 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          lookup_valid,
    input logic                          lookup_hit,
    input logic [WAY_W-1:0]              lookup_way,
    input logic                          fill_valid,
    input logic [WAY_W-1:0]              fill_way,
    input logic                          busy,
    input logic                          victim_valid,
    input logic [WAY_W-1:0]              victim_way,
    input logic [NUM_WAYS-1:0]           way_valid,
    input logic [NUM_WAYS*RRPV_BITS-1:0] set_rrpv
);

    // R8
    victim_in_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> busy);

    // R5
    victim_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (!way_valid[victim_way] ||
            (int'(set_rrpv[int'(victim_way)*RRPV_BITS +: RRPV_BITS]) == RRPV_MAX)));

    // R7
    search_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |=> !busy);

    // R6
    aging_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !victim_valid) |=> busy);

    // R7
    busy_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(way_valid));

    // R2
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fill_valid) |=> way_valid[$past(fill_way)]);

    // R3
    hit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && lookup_valid && lookup_hit && way_valid[lookup_way] &&
         !(fill_valid && fill_way == lookup_way))
        |=> (set_rrpv[int'($past(lookup_way))*RRPV_BITS +: RRPV_BITS] == '0));

endmodule

bind rrip_victim_sel rrip_victim_sel_chk #(
    .NUM_WAYS  (NUM_WAYS),
    .RRPV_BITS (RRPV_BITS)
) u_chk (.*);

// File: tb/rrip_victim_sel_bench.sv
`timescale 1ns/1ps
module rrip_victim_sel_bench;

    localparam int NW   = 4;
    localparam int RB   = 3;
    localparam int WW   = 2;
    localparam int RMAX = 7;
    localparam int RFIL = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lookup_valid = 1'b0;
    logic          lookup_hit = 1'b0;
    logic [WW-1:0] lookup_way = '0;
    logic          fill_valid = 1'b0;
    logic [WW-1:0] fill_way = '0;
    logic          busy, victim_valid;
    logic [WW-1:0] victim_way;
    logic [NW-1:0] way_valid;
    logic [NW*RB-1:0] set_rrpv;

    int checks = 0;
    int failures = 0;
    int mdl_rrpv [NW];
    bit mdl_vld  [NW];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rrip_victim_sel #(.NUM_WAYS(NW), .RRPV_BITS(RB)) u_rrip_victim_sel (
        .clk, .rst_n, .lookup_valid, .lookup_hit, .lookup_way,
        .fill_valid, .fill_way, .busy, .victim_valid, .victim_way,
        .way_valid, .set_rrpv
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        for (int i = 0; i < NW; i++) begin
            chk(way_valid[i] == mdl_vld[i], req, int'(way_valid[i]), int'(mdl_vld[i]));
            chk(int'(set_rrpv[i*RB +: RB]) == mdl_rrpv[i], req,
                int'(set_rrpv[i*RB +: RB]), mdl_rrpv[i]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NW; i++) begin
            mdl_rrpv[i] = RMAX;
            mdl_vld[i]  = 1'b0;
        end
    endtask

    // All tasks start and end at a negative edge
    task automatic do_fill(input int w);
        fill_valid = 1'b1;
        fill_way   = WW'(w);
        @(negedge clk);
        fill_valid = 1'b0;
        mdl_vld[w]  = 1'b1;
        mdl_rrpv[w] = RFIL;
    endtask

    task automatic do_hit(input int w);
        lookup_valid = 1'b1;
        lookup_hit   = 1'b1;
        lookup_way   = WW'(w);
        @(negedge clk);
        lookup_valid = 1'b0;
        lookup_hit   = 1'b0;
        if (mdl_vld[w]) mdl_rrpv[w] = 0;
    endtask

    task automatic do_miss(input bit disturb, output int vway);
        int exp_way = -1;
        int lat = 0;
        int m = 0;
        int k = 0;
        for (int i = NW - 1; i >= 0; i--) if (!mdl_vld[i]) exp_way = i;
        if (exp_way < 0) begin
            for (int i = 0; i < NW; i++) if (mdl_rrpv[i] > m) m = mdl_rrpv[i];
            lat = RMAX - m;
            for (int i = 0; i < NW; i++) mdl_rrpv[i] += lat;
            for (int i = NW - 1; i >= 0; i--) if (mdl_rrpv[i] == RMAX) exp_way = i;
        end
        lookup_valid = 1'b1;
        lookup_hit   = 1'b0;
        @(negedge clk);
        lookup_valid = 1'b0;
        chk(busy == 1'b1, "R7 busy after miss", int'(busy), 1);
        while (!victim_valid && k < 20) begin
            if (disturb && k == 0) begin
                lookup_valid = 1'b1; lookup_hit = 1'b1; lookup_way = 2'd1;
                fill_valid = 1'b1; fill_way = 2'd2;
            end
            if (disturb && k == 1) begin
                lookup_valid = 1'b1; lookup_hit = 1'b0;
            end
            @(negedge clk);
            lookup_valid = 1'b0; lookup_hit = 1'b0; fill_valid = 1'b0;
            k++;
            if (victim_valid == 1'b0)
                chk(busy == 1'b1, "R7 busy while aging", int'(busy), 1);
        end
        chk(victim_valid == 1'b1, "R8 victim strobe", int'(victim_valid), 1);
        chk(k == lat, "R6 aging latency", k, lat);
        chk(int'(victim_way) == exp_way, "R5 victim way", int'(victim_way), exp_way);
        vway = int'(victim_way);
        @(negedge clk);
        chk(busy == 1'b0, "R7 busy drop", int'(busy), 0);
        chk(victim_valid == 1'b0, "R8 single strobe", int'(victim_valid), 0);
        check_state("R6 aged state");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int vw;
        do_reset();
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(victim_valid == 1'b0, "R1 victim_valid", int'(victim_valid), 0);
        check_state("R1 reset");

        // R4 sweep over every valid mask that leaves an invalid way
        for (int mask = 0; mask < (1 << NW) - 1; mask++) begin
            do_reset();
            for (int w = 0; w < NW; w++) if (mask[w]) do_fill(w);
            check_state("R2 fill");
            do_miss(1'b0, vw);
            chk(vw == 0 || mask[vw - 1], "R4 lowest invalid", vw, vw);
        end

        // R3 hit to invalid way ignored, hit to valid way clears
        do_reset();
        do_fill(1);
        do_hit(2);
        check_state("R3 hit invalid ignored");
        do_hit(1);
        check_state("R3 hit valid clears");

        // R2 fill beats hit on the same way
        lookup_valid = 1'b1; lookup_hit = 1'b1; lookup_way = 2'd1;
        fill_valid = 1'b1; fill_way = 2'd1;
        @(negedge clk);
        lookup_valid = 1'b0; lookup_hit = 1'b0; fill_valid = 1'b0;
        mdl_rrpv[1] = RFIL;
        check_state("R2 fill wins");

        // R5/R6 chained sweep over hit masks on a full set
        do_reset();
        for (int w = 0; w < NW; w++) do_fill(w);
        for (int step = 0; step < 48; step++) begin
            int mask = (step * 7 + step / 16) % 16;
            for (int w = 0; w < NW; w++) if (mask[w]) do_hit(w);
            check_state("R3 hit mask");
            do_miss(1'b0, vw);
            do_fill(vw);
            check_state("R2 refill");
        end

        // R7 inputs during a long search are ignored
        do_reset();
        for (int w = 0; w < NW; w++) do_fill(w);
        for (int w = 0; w < NW; w++) do_hit(w);
        do_miss(1'b1, vw);
        chk(vw == 0, "R7 disturbed victim", vw, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule